// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Engine

This block produces the bit-level timing for the master side of an open-drain single-wire bus. It takes one command at a time and performs it as one timed slot on the line. A command is a write-1 slot, a write-0 slot, a read slot, or a reset followed by a check for a target's presence. The block never drives the line high. Its output-enable pulls the line low, and an external pull-up brings the line back high.

All durations are parameters given in microseconds. They are counted on a one-cycle tick-enable input, which the surrounding logic pulses once per microsecond. The line is read back through a two-flop synchronizer. A read bit is decided by when the released line is first seen high. A single fixed sample instant is not used.

A reset first checks that the idle line is high. It checks the line again after the presence window. A line that stays low at either check is reported as a wiring fault, not as a presence result.

Top module: `owm_slot_engine`

## Requirements
- R1: Op code 1 (write-1) drives the line low for exactly T_LOW1 ticks, then releases it; the response arrives T_SLOT+T_REC ticks after acceptance (within two clock cycles).
- R2: Op code 0 (write-0) drives the line low for exactly T_LOW0 ticks, then releases it; the response arrives T_SLOT+T_REC ticks after acceptance (within two clock cycles).
- R3: Op code 2 (read) drives the line low for exactly T_LOWR ticks, then releases it and watches the synchronized line.
- R4: A read returns bit 1 when the released line is first seen high while fewer than T_RDV ticks have passed since the slot began.
- R5: A read returns bit 0 when the line is first seen high at T_RDV ticks or later, or when it is not seen high before T_RDV+2 ticks.
- R6: A read slot ends T_SLOT+T_REC ticks after acceptance, whatever the target does.
- R7: Op code 3 (reset) accepted while the synchronized line is low gives a response in the next cycle with fault=1, presence=0, and the line is never driven.
- R8: A reset drives the line low for T_RSTL ticks. It reports presence=1 when the line is low at T_RSTL+T_PDH+T_PDL/2 ticks after acceptance. The response arrives T_RSTL+T_RSTH ticks after acceptance.
- R9: A reset with the line high at the presence point reports presence=0, fault=0.
- R10: A reset whose line is still low when the slot ends reports fault=1 with presence=0 and bit=0.
- R11: Ready is low from acceptance until the response, the output-enable is only high while busy, and the response valid is a one-cycle pulse.
- R12: Time advances only on cycles where tick is high; with a tick every second cycle, a write-1 low phase lasts 2*T_LOW1 cycles (within one).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per microsecond |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | 0 write-0, 1 write-1, 2 read, 3 reset |
| cmd_ready_o | output | 1 | Engine idle, command accepted when valid |
| rsp_valid_o | output | 1 | One-cycle pulse at the end of a command |
| rsp_bit_o | output | 1 | Bit returned by a read slot |
| rsp_presence_o | output | 1 | A target answered the reset |
| rsp_fault_o | output | 1 | Line stuck low around a reset |
| bus_oe_o | output | 1 | Registered pull-low enable for the open-drain driver |
| bus_i | input | 1 | Raw level of the bus line |

## Verification
A wrong slot counter or a wrong phase shows up on the output-enable within one slot: the low phase comes out with the wrong length, or the response pulse comes early or late. A stale read-watch state gives the wrong bit in the response to the very next read. A wrong presence sample or a missed end-of-slot check flips the presence and fault flags of the reset that is running. The bench therefore measures low-phase lengths and response latencies in clock cycles. It also moves the target's release moment on both sides of the read decision point.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    OP_WR0   = 2'd0,
    OP_WR1   = 2'd1,
    OP_READ  = 2'd2,
    OP_RESET = 2'd3
  } owm_op_e;

  // Ticks during which the master holds the line low.
  function automatic int unsigned drive_len(owm_op_e op, int unsigned low0,
      int unsigned low1, int unsigned lowr, int unsigned rstl);
    case (op)
      OP_WR0:  return low0;
      OP_WR1:  return low1;
      OP_READ: return lowr;
      default: return rstl;
    endcase
  endfunction

  // Ticks from acceptance to the end of the command.
  function automatic int unsigned slot_len(owm_op_e op, int unsigned slot,
      int unsigned rec, int unsigned rstl, int unsigned rsth);
    return (op == OP_RESET) ? (rstl + rsth) : (slot + rec);
  endfunction

  // Tick count at which a reset samples the target's answer.
  function automatic int unsigned presence_point(int unsigned rstl,
      int unsigned pdh, int unsigned pdl);
    return rstl + pdh + pdl / 2;
  endfunction

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  // Idle bus level is high, so the chain resets to ones.
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/owm_slot_timer.sv
module owm_slot_timer #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                            cnt_o <= '0;
    else if (clr_i)                        cnt_o <= '0;
    else if (run_i && tick_i && cnt_o != '1) cnt_o <= cnt_o + 1'b1;
  end

  // R12: time only moves on tick cycles
  p_hold_no_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
  import owm_pkg::*;
#(
  parameter int unsigned T_SLOT = 60,
  parameter int unsigned T_REC  = 5,
  parameter int unsigned T_LOW1 = 6,
  parameter int unsigned T_LOW0 = 60,
  parameter int unsigned T_LOWR = 5,
  parameter int unsigned T_RDV  = 15,
  parameter int unsigned T_RSTL = 480,
  parameter int unsigned T_RSTH = 480,
  parameter int unsigned T_PDH  = 15,
  parameter int unsigned T_PDL  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  output logic       cmd_ready_o,
  output logic       rsp_valid_o,
  output logic       rsp_bit_o,
  output logic       rsp_presence_o,
  output logic       rsp_fault_o,
  output logic       bus_oe_o,
  input  logic       bus_i
);
  localparam int unsigned RW_LEN  = T_SLOT + T_REC;
  localparam int unsigned RST_LEN = T_RSTL + T_RSTH;
  localparam int unsigned MAXLEN  = (RW_LEN > RST_LEN) ? RW_LEN : RST_LEN;
  localparam int unsigned CW      = $clog2(MAXLEN + 2);
  localparam logic [CW-1:0] RDV_C = CW'(T_RDV);
  localparam logic [CW-1:0] WIN_C = CW'(T_RDV + 2);
  localparam logic [CW-1:0] PRS_C = CW'(presence_point(T_RSTL, T_PDH, T_PDL));

  logic          bus_s;
  logic          busy_q, oe_q, seen_q, rbit_q, pres_q;
  owm_op_e       op_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] low_len, total_len;
  logic [CW:0]   cnt_nx;

  owm_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(bus_i), .q_o(bus_s)
  );

  // Named events for the assertions
  logic accept, pre_fault, start, released, slot_done;
  logic rd_window, rise_seen, pres_sample, post_fault, low_end;

  assign accept    = cmd_valid_i && !busy_q;
  assign pre_fault = accept && (owm_op_e'(cmd_op_i) == OP_RESET) && !bus_s;
  assign start     = accept && !pre_fault;

  assign low_len   = CW'(drive_len(op_q, T_LOW0, T_LOW1, T_LOWR, T_RSTL));
  assign total_len = CW'(slot_len(op_q, T_SLOT, T_REC, T_RSTL, T_RSTH));
  assign cnt_nx    = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};

  assign released    = busy_q && (cnt >= low_len);
  assign slot_done   = busy_q && (cnt >= total_len);
  assign low_end     = busy_q && tick_i && (cnt_nx >= {1'b0, low_len});
  assign rd_window   = released && (op_q == OP_READ) && !seen_q && (cnt < WIN_C);
  assign rise_seen   = rd_window && bus_s;
  assign pres_sample = busy_q && (op_q == OP_RESET) && (cnt == PRS_C);
  assign post_fault  = slot_done && (op_q == OP_RESET) && !bus_s;

  owm_slot_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(start),
    .run_i(busy_q && !slot_done), .tick_i(tick_i), .cnt_o(cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q         <= 1'b0;
      op_q           <= OP_WR0;
      oe_q           <= 1'b0;
      seen_q         <= 1'b0;
      rbit_q         <= 1'b0;
      pres_q         <= 1'b0;
      rsp_valid_o    <= 1'b0;
      rsp_bit_o      <= 1'b0;
      rsp_presence_o <= 1'b0;
      rsp_fault_o    <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (pre_fault) begin
        rsp_valid_o    <= 1'b1;
        rsp_bit_o      <= 1'b0;
        rsp_presence_o <= 1'b0;
        rsp_fault_o    <= 1'b1;
      end else if (start) begin
        busy_q <= 1'b1;
        op_q   <= owm_op_e'(cmd_op_i);
        oe_q   <= 1'b1;
        seen_q <= 1'b0;
        rbit_q <= 1'b0;
        pres_q <= 1'b0;
      end else if (busy_q) begin
        if (low_end) oe_q <= 1'b0;
        if (rise_seen) begin
          seen_q <= 1'b1;
          rbit_q <= (cnt < RDV_C);
        end
        if (pres_sample) pres_q <= !bus_s;
        if (slot_done) begin
          busy_q         <= 1'b0;
          oe_q           <= 1'b0;
          rsp_valid_o    <= 1'b1;
          rsp_bit_o      <= (op_q == OP_READ) && rbit_q;
          rsp_presence_o <= pres_q && !post_fault;
          rsp_fault_o    <= post_fault;
        end
      end
    end
  end

  assign cmd_ready_o = !busy_q;
  assign bus_oe_o    = oe_q;

  // R11: the line is only pulled while a command runs
  p_oe_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> !cmd_ready_o);
  // R11: response valid lasts one cycle
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);
  // R7: stuck-low line before reset ends at once without driving
  p_prefault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pre_fault |=> (rsp_valid_o && rsp_fault_o && !bus_oe_o));
  // R10: a fault carries no presence and no data bit
  p_fault_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_fault_o) |-> (!rsp_presence_o && !rsp_bit_o));
  // R3: the line is only pulled low right after an accepted command
  p_oe_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_o) |-> $past(cmd_valid_i && cmd_ready_o));
endmodule

// File: tb/tb_owm_slot_engine.sv
module tb_owm_slot_engine;
  localparam int T_SLOT = 60, T_REC = 5, T_LOW1 = 6, T_LOW0 = 60, T_LOWR = 5;
  localparam int T_RDV = 15, T_RSTL = 480, T_RSTH = 480, T_PDH = 15, T_PDL = 60;
  localparam int RW_TOT = T_SLOT + T_REC;
  localparam int RS_TOT = T_RSTL + T_RSTH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic tgt_low = 1'b0;
  logic cmd_ready, rsp_valid, rsp_bit, rsp_pres, rsp_fault, bus_oe;
  wire  bus_line = !(bus_oe || tgt_low);

  int checks = 0, failures = 0, tick_div = 1;
  int lat, oe_cyc;
  bit busy_seen_ready, finished = 0;

  always #10 clk = ~clk;

  owm_slot_engine #(
    .T_SLOT(T_SLOT), .T_REC(T_REC), .T_LOW1(T_LOW1), .T_LOW0(T_LOW0),
    .T_LOWR(T_LOWR), .T_RDV(T_RDV), .T_RSTL(T_RSTL), .T_RSTH(T_RSTH),
    .T_PDH(T_PDH), .T_PDL(T_PDL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cmd_valid_i(cmd_valid),
    .cmd_op_i(cmd_op), .cmd_ready_o(cmd_ready), .rsp_valid_o(rsp_valid),
    .rsp_bit_o(rsp_bit), .rsp_presence_o(rsp_pres), .rsp_fault_o(rsp_fault),
    .bus_oe_o(bus_oe), .bus_i(bus_line)
  );

  initial begin : tick_gen
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      ph = ph + 1;
      tick = (tick_div <= 1) ? 1'b1 : ((ph % tick_div) == 0);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(string tag, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // Issue one command; target pulls low for cycles [from,to) counted after acceptance.
  task automatic run_cmd(logic [1:0] op, int from, int to);
    int k;
    bit done;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    k = 0; oe_cyc = 0; done = 0; busy_seen_ready = 0;
    while (!done && k < 3000) begin
      if (k > 0) @(negedge clk);
      tgt_low = (k >= from && k < to);
      if (bus_oe) oe_cyc++;
      if (rsp_valid) done = 1;
      else begin
        if (cmd_ready) busy_seen_ready = 1;
        k++;
      end
    end
    lat = k;
    tgt_low = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R11 ready after reset", cmd_ready, 1);
    chk("R11 oe after reset", bus_oe, 0);
    chk("R11 rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic t_write1();
    run_cmd(2'd1, 0, 0);
    chk("R1 write-1 low cycles", oe_cyc, T_LOW1);
    chk_rng("R1 write-1 latency", lat, RW_TOT, RW_TOT + 2);
    chk("R11 ready low while busy", busy_seen_ready, 0);
  endtask

  task automatic t_write0();
    run_cmd(2'd0, 0, 0);
    chk("R2 write-0 low cycles", oe_cyc, T_LOW0);
    chk_rng("R2 write-0 latency", lat, RW_TOT, RW_TOT + 2);
  endtask

  task automatic t_reads();
    run_cmd(2'd2, 0, 0);
    chk("R3 read low cycles", oe_cyc, T_LOWR);
    chk("R4 read, target silent", rsp_bit, 1);
    chk_rng("R6 read latency, quick rise", lat, RW_TOT, RW_TOT + 2);
    run_cmd(2'd2, 0, 10);
    chk("R4 read, release before decision", rsp_bit, 1);
    run_cmd(2'd2, 0, 20);
    chk("R5 read, release after decision", rsp_bit, 0);
    run_cmd(2'd2, 0, 40);
    chk("R5 read, held low", rsp_bit, 0);
    chk_rng("R6 read latency, held low", lat, RW_TOT, RW_TOT + 2);
  endtask

  task automatic t_resets();
    run_cmd(2'd3, T_RSTL + 20, T_RSTL + 120);
    chk("R8 reset low cycles", oe_cyc, T_RSTL);
    chk("R8 presence detected", rsp_pres, 1);
    chk("R8 no fault", rsp_fault, 0);
    chk_rng("R8 reset latency", lat, RS_TOT, RS_TOT + 2);
    run_cmd(2'd3, 0, 0);
    chk("R9 presence absent", rsp_pres, 0);
    chk("R9 no fault", rsp_fault, 0);
    run_cmd(2'd3, T_RSTL + 20, 100000);
    chk("R10 late stuck fault", rsp_fault, 1);
    chk("R10 presence cleared", rsp_pres, 0);
  endtask

  task automatic t_prefault();
    @(negedge clk);
    tgt_low = 1'b1;
    repeat (4) @(negedge clk);
    run_cmd(2'd3, 0, 100000);
    chk("R7 early fault latency", lat, 0);
    chk("R7 early fault flag", rsp_fault, 1);
    chk("R7 line never driven", oe_cyc, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_slow_tick();
    tick_div = 2;
    run_cmd(2'd1, 0, 0);
    chk_rng("R12 low phase with half-rate tick", oe_cyc, 2 * T_LOW1 - 1, 2 * T_LOW1 + 1);
    tick_div = 1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_write1();
    t_write0();
    t_reads();
    t_resets();
    t_prefault();
    t_slow_tick();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule